// File: doc/BRIEF.md
# Two-Bridge Fixed-Frequency Current Chopper

This block decides, cycle by cycle, whether the high-side (source) switches of two H-bridges may conduct. A free-running period timer produces one tick per chopping period, and that tick arms a per-bridge enable latch for both bridges together. Each bridge has an asynchronous over-current comparator input. Once that input is brought into the clock domain, a trip disarms only the latch of that bridge. The source stays off until the next common tick. This gives fixed-frequency, variable-duty current regulation: the on-time ends at the trip and the rest of the period is decay time.

Switching transients would otherwise produce false trips. Each bridge therefore runs a blanking window in which its comparator is ignored. The window starts whenever that bridge's source turns on, and a longer window starts whenever its commanded polarity changes. A global bypass input turns chopping off so that the source enables follow the run commands alone. A bridge that is not commanded to conduct, whether it is braking or disabled, keeps its source off and ignores trips. The run and polarity commands come from an outside decoder.

Top module: `chop_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after a clock edge that sampled `rst` high, every bit of `src_en_o` is 0.
- R2: The period tick occurs on every PERIOD_CYC-th clock edge after reset release (edges PERIOD_CYC, 2·PERIOD_CYC, ...). It re-arms every running bridge together, and a bridge that was tripped drives `src_en_o[b]`=1 after that edge.
- R3: A trip on `trip_i[b]` outside blanking drives `src_en_o[b]` to 0 and leaves the other bridge's `src_en_o` unchanged. Bit b of every vector port belongs to bridge b.
- R4: For BLANK_ON_CYC edges after the edge that turns a source on, trips on that bridge are ignored. On the next edge a held trip clears the source.
- R5: A change of `dir_i[b]` while `run_i[b]`=1 opens a BLANK_DIR_CYC-edge window in which trips on that bridge are ignored. A new window never shortens one already running.
- R6: When a tick and an accepted trip fall on the same edge, the trip wins and the source stays off. When the trip falls inside blanking, the tick wins and the source turns on.
- R7: While `chop_off_i`=1, `src_en_o` equals `run_i` one edge later, and trips have no effect.
- R8: While `run_i[b]`=0 (brake or disable), `src_en_o[b]` is 0 one edge later and trips are ignored. When `run_i[b]` rises, the source turns on at the next edge, with turn-on blanking.
- R9: A trip input change reaches `src_en_o` on the third clock edge after it is applied: two synchronizer stages, then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chop_off_i | input | 1 | 1 = current chopping bypassed; sources follow the run commands |
| run_i | input | NB | Per bridge: 1 = commanded to conduct (forward or reverse), 0 = brake or disabled |
| dir_i | input | NB | Per bridge: commanded current polarity |
| trip_i | input | NB | Per bridge: asynchronous current-trip comparator output, 1 = over threshold |
| src_en_o | output | NB | Per bridge: registered source-switch enable |

## Verification
The period tick and a trip can be accepted on the same clock edge. The bench provokes this by applying a trip exactly three edges before a known tick edge, since tick edges are multiples of the period counted from reset release. It does this once on a bridge with no blanking, where the source must stay off, and once on a bridge whose polarity change has opened a window, where the source must turn on and is then cleared when the window expires. Both cases are judged on `src_en_o` alone. The two bridges are tripped at different edges to show that one bridge's clear leaves the other bridge's enable unchanged.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
package chop_pkg;

  // larger of two cycle counts, used to size shared counters
  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to hold values 0..n
  function automatic int unsigned bits_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/chop_sync2.sv
`timescale 1ns/1ps
module chop_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/chop_period_timer.sv
`timescale 1ns/1ps
module chop_period_timer
  import chop_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 7874
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned CW = bits_for(PERIOD_CYC - 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/chop_blank_timer.sv
`timescale 1ns/1ps
module chop_blank_timer
  import chop_pkg::*;
#(
  parameter int unsigned ON_CYC  = 260,
  parameter int unsigned DIR_CYC = 360
) (
  input  logic clk,
  input  logic rst,
  input  logic start_on_i,
  input  logic start_dir_i,
  output logic active_o
);
  localparam int unsigned MAXC = max_u(ON_CYC, DIR_CYC);
  localparam int unsigned CW   = bits_for(MAXC);

  logic [CW-1:0] cnt_q, dec, req_on, req_dir, req;

  always_comb begin
    dec     = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    req_on  = start_on_i  ? CW'(ON_CYC)  : '0;
    req_dir = start_dir_i ? CW'(DIR_CYC) : '0;
    req     = (req_dir > req_on) ? req_dir : req_on;
  end

  // a new window only ever extends the remaining one
  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= (req > dec) ? req : dec;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/chop_bridge.sv
`timescale 1ns/1ps
module chop_bridge #(
  parameter int unsigned ON_CYC  = 260,
  parameter int unsigned DIR_CYC = 360
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic chop_off_i,
  input  logic run_i,
  input  logic dir_i,
  input  logic trip_i,
  output logic src_en_o,
  output logic blank_o
);
  logic arm_q, on_q, dir_q;
  logic arm_d, on_d, trip_ok, start_on, start_dir;

  always_comb begin
    trip_ok = trip_i & ~blank_o & run_i & ~chop_off_i;
    if (!run_i || chop_off_i) arm_d = 1'b1;
    else if (trip_ok)         arm_d = 1'b0;
    else if (tick_i)          arm_d = 1'b1;
    else                      arm_d = arm_q;
    on_d      = run_i & arm_d;
    start_on  = on_d & ~on_q;
    start_dir = run_i & (dir_i != dir_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= 1'b1;
      on_q  <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      arm_q <= arm_d;
      on_q  <= on_d;
      dir_q <= dir_i;
    end
  end

  chop_blank_timer #(
    .ON_CYC (ON_CYC),
    .DIR_CYC(DIR_CYC)
  ) u_blank (
    .clk        (clk),
    .rst        (rst),
    .start_on_i (start_on),
    .start_dir_i(start_dir),
    .active_o   (blank_o)
  );

  assign src_en_o = on_q;
endmodule

// File: rtl/chop_ctrl.sv
`timescale 1ns/1ps
module chop_ctrl #(
  parameter int unsigned NB            = 2,
  parameter int unsigned PERIOD_CYC    = 7874,
  parameter int unsigned BLANK_ON_CYC  = 260,
  parameter int unsigned BLANK_DIR_CYC = 360
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chop_off_i,
  input  logic [NB-1:0] run_i,
  input  logic [NB-1:0] dir_i,
  input  logic [NB-1:0] trip_i,
  output logic [NB-1:0] src_en_o
);
  logic          period_tick;
  logic [NB-1:0] trip_sync;
  logic [NB-1:0] blank_act;

  chop_sync2 #(.W(NB)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .async_i(trip_i),
    .sync_o (trip_sync)
  );

  chop_period_timer #(.PERIOD_CYC(PERIOD_CYC)) u_period (
    .clk   (clk),
    .rst   (rst),
    .tick_o(period_tick)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bridge
    chop_bridge #(
      .ON_CYC (BLANK_ON_CYC),
      .DIR_CYC(BLANK_DIR_CYC)
    ) u_br (
      .clk       (clk),
      .rst       (rst),
      .tick_i    (period_tick),
      .chop_off_i(chop_off_i),
      .run_i     (run_i[b]),
      .dir_i     (dir_i[b]),
      .trip_i    (trip_sync[b]),
      .src_en_o  (src_en_o[b]),
      .blank_o   (blank_act[b])
    );
  end
endmodule

// File: rtl/chop_ctrl_chk.sv
`timescale 1ns/1ps
module chop_ctrl_chk #(
  parameter int unsigned NB = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          chop_off_i,
  input logic [NB-1:0] run_i,
  input logic [NB-1:0] src_en_o,
  input logic [NB-1:0] trip_sync,
  input logic [NB-1:0] blank_act,
  input logic          period_tick
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (src_en_o == '0));

  p_bypass_follow_r7: assert property (@(posedge clk) disable iff (rst)
    chop_off_i |=> (src_en_o == $past(run_i)));

  for (genvar b = 0; b < NB; b++) begin : g_chk
    p_idle_off_r8: assert property (@(posedge clk) disable iff (rst)
      !run_i[b] |=> !src_en_o[b]);

    p_trip_clear_r3: assert property (@(posedge clk) disable iff (rst)
      (run_i[b] && !chop_off_i && trip_sync[b] && !blank_act[b]) |=> !src_en_o[b]);

    p_blank_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (src_en_o[b] && blank_act[b] && run_i[b] && !chop_off_i) |=> src_en_o[b]);

    p_rise_cause_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(src_en_o[b]) |-> ($past(period_tick) || $past(chop_off_i) ||
                              !$past(run_i[b], 2) || $past(rst, 2)));
  end
endmodule

bind chop_ctrl chop_ctrl_chk #(.NB(NB)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .chop_off_i (chop_off_i),
  .run_i      (run_i),
  .src_en_o   (src_en_o),
  .trip_sync  (trip_sync),
  .blank_act  (blank_act),
  .period_tick(period_tick)
);

// File: tb/chop_ctrl_tb.sv
`timescale 1ns/1ps
module chop_ctrl_tb;
  localparam int unsigned NB = 2;
  localparam int unsigned P  = 40;
  localparam int unsigned BON = 4;
  localparam int unsigned BDIR = 8;

  typedef struct packed {
    logic [15:0] k;     // check state after this edge, then apply inputs
    logic [1:0]  run;
    logic [1:0]  dir;
    logic [1:0]  trip;
    logic        off;
    logic [1:0]  exp;
    logic [3:0]  req;
  } row_t;

  localparam int N = 31;
  localparam row_t TBL [0:N-1] = '{
    '{16'd1,   2'b11, 2'b00, 2'b00, 1'b0, 2'b11, 4'd8}, // R8 start after reset
    '{16'd9,   2'b11, 2'b00, 2'b01, 1'b0, 2'b11, 4'd3}, // R3 trip bridge 0
    '{16'd11,  2'b11, 2'b00, 2'b01, 1'b0, 2'b11, 4'd9}, // R9 not yet through sync
    '{16'd12,  2'b11, 2'b00, 2'b00, 1'b0, 2'b10, 4'd3}, // R3 only bridge 0 cleared
    '{16'd39,  2'b11, 2'b00, 2'b00, 1'b0, 2'b10, 4'd2}, // R2 before tick
    '{16'd40,  2'b11, 2'b00, 2'b11, 1'b0, 2'b11, 4'd2}, // R2 tick re-arms
    '{16'd42,  2'b11, 2'b00, 2'b11, 1'b0, 2'b11, 4'd9}, // R9
    '{16'd43,  2'b11, 2'b00, 2'b11, 1'b0, 2'b01, 4'd3}, // R3 bridge 1 cleared
    '{16'd44,  2'b11, 2'b00, 2'b11, 1'b0, 2'b01, 4'd4}, // R4 bridge 0 blanked
    '{16'd45,  2'b11, 2'b00, 2'b00, 1'b0, 2'b00, 4'd4}, // R4 window over
    '{16'd77,  2'b11, 2'b00, 2'b10, 1'b0, 2'b00, 4'd6}, // R6 trip lands on tick
    '{16'd80,  2'b11, 2'b00, 2'b00, 1'b0, 2'b01, 4'd6}, // R6 trip wins
    '{16'd100, 2'b11, 2'b00, 2'b00, 1'b0, 2'b01, 4'd6}, // R6 still off
    '{16'd115, 2'b11, 2'b10, 2'b00, 1'b0, 2'b01, 4'd5}, // R5 polarity change
    '{16'd117, 2'b11, 2'b10, 2'b10, 1'b0, 2'b01, 4'd5}, // R5 trip in window
    '{16'd119, 2'b11, 2'b10, 2'b10, 1'b0, 2'b01, 4'd6}, // R6 before tick
    '{16'd120, 2'b11, 2'b10, 2'b10, 1'b0, 2'b11, 4'd6}, // R6 tick wins
    '{16'd124, 2'b11, 2'b10, 2'b10, 1'b0, 2'b11, 4'd5}, // R5 window kept
    '{16'd125, 2'b11, 2'b10, 2'b00, 1'b0, 2'b01, 4'd4}, // R4 cleared after window
    '{16'd130, 2'b11, 2'b11, 2'b00, 1'b0, 2'b01, 4'd5}, // R5 polarity bridge 0
    '{16'd131, 2'b11, 2'b11, 2'b01, 1'b0, 2'b01, 4'd5}, // R5 trip bridge 0
    '{16'd139, 2'b11, 2'b11, 2'b01, 1'b0, 2'b01, 4'd5}, // R5 longer than turn-on
    '{16'd140, 2'b11, 2'b11, 2'b00, 1'b0, 2'b00, 4'd5}, // R5 window over
    '{16'd145, 2'b11, 2'b11, 2'b00, 1'b1, 2'b00, 4'd7}, // R7 bypass on
    '{16'd146, 2'b11, 2'b11, 2'b11, 1'b1, 2'b11, 4'd7}, // R7 follows run
    '{16'd153, 2'b11, 2'b11, 2'b00, 1'b1, 2'b11, 4'd7}, // R7 trips ignored
    '{16'd155, 2'b10, 2'b11, 2'b00, 1'b1, 2'b11, 4'd7}, // R7
    '{16'd156, 2'b10, 2'b11, 2'b00, 1'b0, 2'b10, 4'd8}, // R8 bridge 0 idle
    '{16'd160, 2'b10, 2'b11, 2'b01, 1'b0, 2'b10, 4'd8}, // R8 tick, idle stays off
    '{16'd168, 2'b10, 2'b11, 2'b00, 1'b0, 2'b10, 4'd8}, // R8 trip on idle bridge
    '{16'd171, 2'b11, 2'b11, 2'b00, 1'b0, 2'b10, 4'd8}  // R8 run returns
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chop_off_i = 1'b0;
  logic [NB-1:0] run_i = '0;
  logic [NB-1:0] dir_i = '0;
  logic [NB-1:0] trip_i = '0;
  logic [NB-1:0] src_en_o;
  int ecount = 0;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) ecount <= 0;
    else     ecount <= ecount + 1;
  end

  chop_ctrl #(
    .NB(NB), .PERIOD_CYC(P), .BLANK_ON_CYC(BON), .BLANK_DIR_CYC(BDIR)
  ) u_dut (
    .clk(clk), .rst(rst), .chop_off_i(chop_off_i),
    .run_i(run_i), .dir_i(dir_i), .trip_i(trip_i), .src_en_o(src_en_o)
  );

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input logic [3:0] r);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s src_en_o=%b expected %b (edge %0d)", req_name(r), act, exp, ecount);
    end
  endtask

  initial begin
    run_i = 2'b11;
    repeat (3) @(negedge clk);
    check(src_en_o, 2'b00, 4'd1);          // R1 held in reset
    rst = 1'b0;
    for (int i = 0; i < N; i++) begin
      while (ecount < int'(TBL[i].k)) @(negedge clk);
      check(src_en_o, TBL[i].exp, TBL[i].req);
      run_i      = TBL[i].run;
      dir_i      = TBL[i].dir;
      trip_i     = TBL[i].trip;
      chop_off_i = TBL[i].off;
    end
    // R1: reset in the middle of running
    @(negedge clk);
    check(src_en_o, 2'b11, 4'd8);          // R8 turned on with run
    rst = 1'b1;
    @(negedge clk);
    check(src_en_o, 2'b00, 4'd1);          // R1 cleared by reset
    rst = 1'b0;
    @(negedge clk);
    check(src_en_o, 2'b11, 4'd2);          // R2/R8 restart after reset
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1-R9 actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule